// File: doc/BRIEF.md
# Outbound Window Enable Decoder

This block makes two address decisions for a bridge between a CPU and a PCI memory bus. On the outbound side it looks at a CPU address in the top 256 MiB of the 32-bit space. That region is cut into thirty-two 8 MiB chunks. The block decides whether the bridge should claim the access and forward it to PCI memory. Each chunk has its own bit in a 32-bit enable word. A two-bit field in a control word acts as a master switch for all of them. The lowest chunk and the highest chunk are reserved for boot firmware and for the bridge's own registers, so they are never claimed.

On the inbound side, a bus-master address from a PCI device is sorted into one of four classes: system memory, a loop back to PCI memory, the CPU's local region, or no target. Each side has its own address and valid strobe. Each registers its answer one cycle after the strobe and holds that answer until the next strobe. Moving the data itself is outside this block.

Top module: `pci_window_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, `fwd_vld`, `fwd_hit`, `in_vld` are 0, `fwd_chunk` is 0 and `in_dest` is 0.
- R2: `fwd_vld` is 1 in exactly the cycle after `cpu_vld` was sampled high. `in_vld` is 1 in exactly the cycle after `bm_vld` was sampled high.
- R3: Forwarding is on only when `ctrl[8:7]` equals 2'b01. With 00, 10 or 11 no address is claimed. All other bits of `ctrl` have no effect.
- R4: An address in 0xF0000000 + i*0x800000 ... + 0x7FFFFF, for i from 1 to 30, is claimed (`fwd_hit`=1) when forwarding is on and `win_en[i]` is 1. `fwd_chunk` then reports i. When nothing is claimed, `fwd_chunk` is 0.
- R5: Chunk 0 (0xF0000000-0xF07FFFFF) and chunk 31 (0xFF800000-0xFFFFFFFF) are never claimed, whatever `win_en[0]` and `win_en[31]` hold.
- R6: Addresses below 0xF0000000 are never claimed.
- R7: Inbound addresses 0x00000000-0xF07FFFFF give `in_dest` = 1 (system memory).
- R8: Inbound addresses 0xF0800000-0xFF7FFFFF give `in_dest` = 2 (PCI memory).
- R9: Inbound addresses 0xFFF00000-0xFFFFEFFF give `in_dest` = 3 (CPU region).
- R10: Inbound addresses 0xFF800000-0xFFEFFFFF and 0xFFFFF000-0xFFFFFFFF give `in_dest` = 0 (no target).
- R11: While no strobe arrives, a decision already made holds. Changes to `win_en` or `ctrl` apply from the next strobed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_vld | input | 1 | Outbound address strobe |
| cpu_addr | input | 32 | CPU-side address |
| win_en | input | 32 | Per-chunk forwarding enables |
| ctrl | input | 32 | Control word, master switch in bits [8:7] |
| bm_vld | input | 1 | Inbound address strobe |
| bm_addr | input | 32 | PCI bus-master address |
| fwd_vld | output | 1 | Outbound decision valid |
| fwd_hit | output | 1 | Claim and forward to PCI memory |
| fwd_chunk | output | 5 | Index of the claimed chunk, 0 if none |
| in_vld | output | 1 | Inbound decision valid |
| in_dest | output | 2 | Inbound destination code |

## Verification
The outbound decoder is swept over every chunk. In each chunk it is tried at the first byte, the last byte and one interior address. This is repeated under all four master-switch codes, with random-looking noise in the other control bits. It runs against all-ones, all-zeros, alternating and walking-one enable words. These show the chunk index is taken from the right address bits, the two end chunks are masked, and the switch needs the exact value 01.

Addresses below the region check that the low space is never claimed. An enable change made while the strobe is idle shows that a decision holds and that the new settings apply only to the next strobe. The inbound decoder is stepped through the whole space at 1 MiB spacing and also probed one byte either side of every range edge.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_SYS  = 2'd1,
    DST_PCI  = 2'd2,
    DST_CPU  = 2'd3
  } dest_e;

  localparam int unsigned SWITCH_W = 2;
endpackage

// File: rtl/pwd_out_decode.sv
module pwd_out_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
  parameter int unsigned CHUNK_LG = 23,
  parameter int unsigned NCHUNK   = 32,
  parameter logic [1:0]  SW_ON    = 2'b01,
  localparam int unsigned IDX_W   = $clog2(NCHUNK)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCHUNK-1:0] en,
  input  logic [1:0]        sw,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  // usable enables: end chunks forced off
  logic [NCHUNK-1:0] en_usable;
  genvar g;
  generate
    for (g = 0; g < NCHUNK; g++) begin : g_mask
      if (g == 0 || g == NCHUNK - 1) begin : g_rsv
        assign en_usable[g] = 1'b0;
      end else begin : g_open
        assign en_usable[g] = en[g];
      end
    end
  endgenerate

  function automatic logic [ADDR_W:0] offset_of(input logic [ADDR_W-1:0] a);
    return {1'b0, a} - {1'b0, WIN_BASE};
  endfunction

  function automatic logic inside_region(input logic [ADDR_W:0] off);
    return !off[ADDR_W] && ((off[ADDR_W-1:0] >> CHUNK_LG) < ADDR_W'(NCHUNK));
  endfunction

  logic [ADDR_W:0] off;
  logic            in_reg;
  logic            sw_on;

  assign off    = offset_of(addr);
  assign in_reg = inside_region(off);
  assign sw_on  = (sw == SW_ON);
  assign idx    = IDX_W'(off[ADDR_W-1:0] >> CHUNK_LG);
  assign hit    = sw_on && in_reg && en_usable[idx];
endmodule

// File: rtl/pwd_in_decode.sv
module pwd_in_decode
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
  parameter int unsigned CHUNK_LG = 23,
  parameter int unsigned NCHUNK   = 32,
  parameter logic [ADDR_W-1:0] CPU_LO = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] CPU_HI = 32'hFFFF_EFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output dest_e             dest
);
  localparam logic [ADDR_W:0] CHUNK   = (ADDR_W+1)'(1) << CHUNK_LG;
  localparam logic [ADDR_W:0] SYS_END = {1'b0, WIN_BASE} + CHUNK;
  localparam logic [ADDR_W:0] PCI_END = SYS_END + CHUNK * (ADDR_W+1)'(NCHUNK - 2);

  function automatic dest_e classify(input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] w;
    w = {1'b0, a};
    if (w < SYS_END)                    return DST_SYS;
    else if (w < PCI_END)               return DST_PCI;
    else if (a >= CPU_LO && a <= CPU_HI) return DST_CPU;
    else                                return DST_NONE;
  endfunction

  assign dest = classify(addr);
endmodule

// File: rtl/pci_window_decoder.sv
module pci_window_decoder
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
  parameter int unsigned CHUNK_LG = 23,
  parameter int unsigned NCHUNK   = 32,
  parameter int unsigned SW_LSB   = 7,
  parameter logic [1:0]  SW_ON    = 2'b01,
  parameter logic [ADDR_W-1:0] CPU_LO = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] CPU_HI = 32'hFFFF_EFFF,
  localparam int unsigned IDX_W   = $clog2(NCHUNK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_vld,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NCHUNK-1:0] win_en,
  input  logic [ADDR_W-1:0] ctrl,
  input  logic              bm_vld,
  input  logic [ADDR_W-1:0] bm_addr,
  output logic              fwd_vld,
  output logic              fwd_hit,
  output logic [IDX_W-1:0]  fwd_chunk,
  output logic              in_vld,
  output logic [1:0]        in_dest
);
  logic [SWITCH_W-1:0] sw_field;
  logic                ctl_unused;
  logic                out_hit_c;
  logic [IDX_W-1:0]    out_idx_c;
  dest_e               in_dest_c;

  assign sw_field   = ctrl[SW_LSB +: SWITCH_W];
  assign ctl_unused = ^{ctrl[ADDR_W-1:SW_LSB+SWITCH_W], ctrl[SW_LSB-1:0]};

  pwd_out_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .CHUNK_LG(CHUNK_LG),
    .NCHUNK(NCHUNK), .SW_ON(SW_ON)
  ) u_out (
    .addr(cpu_addr), .en(win_en), .sw(sw_field),
    .hit(out_hit_c), .idx(out_idx_c)
  );

  pwd_in_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .CHUNK_LG(CHUNK_LG),
    .NCHUNK(NCHUNK), .CPU_LO(CPU_LO), .CPU_HI(CPU_HI)
  ) u_in (
    .addr(bm_addr), .dest(in_dest_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_vld   <= 1'b0;
      fwd_hit   <= 1'b0;
      fwd_chunk <= '0;
    end else begin
      fwd_vld <= cpu_vld;
      if (cpu_vld) begin
        fwd_hit   <= out_hit_c;
        fwd_chunk <= out_hit_c ? out_idx_c : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_vld  <= 1'b0;
      in_dest <= DST_NONE;
    end else begin
      in_vld <= bm_vld;
      if (bm_vld) in_dest <= in_dest_c;
    end
  end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
  parameter int unsigned NCHUNK   = 32,
  parameter logic [1:0]  SW_ON    = 2'b01,
  parameter logic [ADDR_W-1:0] CPU_LO = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] CPU_HI = 32'hFFFF_EFFF,
  localparam int unsigned IDX_W   = $clog2(NCHUNK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_vld,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [1:0]        sw_field,
  input logic              bm_vld,
  input logic [ADDR_W-1:0] bm_addr,
  input logic              fwd_vld,
  input logic              fwd_hit,
  input logic [IDX_W-1:0]  fwd_chunk,
  input logic              in_vld,
  input logic [1:0]        in_dest
);
  AST_FWD_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vld |=> fwd_vld); // R2
  AST_FWD_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_vld |=> !fwd_vld); // R2
  AST_IN_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bm_vld |=> in_vld); // R2
  AST_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vld && sw_field != SW_ON) |=> !fwd_hit); // R3
  AST_END_CHUNKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_vld && fwd_hit) |-> (fwd_chunk != '0 && fwd_chunk != IDX_W'(NCHUNK - 1))); // R5
  AST_LOW_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vld && cpu_addr < WIN_BASE) |=> !fwd_hit); // R6
  AST_CPU_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_vld && bm_addr >= CPU_LO && bm_addr <= CPU_HI) |=> in_dest == 2'd3); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_vld |=> ($stable(fwd_hit) && $stable(fwd_chunk))); // R11
endmodule

bind pci_window_decoder pwd_checker #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .NCHUNK(NCHUNK), .SW_ON(SW_ON),
  .CPU_LO(CPU_LO), .CPU_HI(CPU_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_vld(cpu_vld), .cpu_addr(cpu_addr),
  .sw_field(sw_field), .bm_vld(bm_vld), .bm_addr(bm_addr),
  .fwd_vld(fwd_vld), .fwd_hit(fwd_hit), .fwd_chunk(fwd_chunk),
  .in_vld(in_vld), .in_dest(in_dest)
);

// File: tb/sim_pci_window_decoder.sv
module sim_pci_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_vld = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] win_en = '0;
  logic [31:0] ctrl = '0;
  logic        bm_vld = 1'b0;
  logic [31:0] bm_addr = '0;
  logic        fwd_vld, fwd_hit, in_vld;
  logic [4:0]  fwd_chunk;
  logic [1:0]  in_dest;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pci_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cpu_vld(cpu_vld), .cpu_addr(cpu_addr),
    .win_en(win_en), .ctrl(ctrl), .bm_vld(bm_vld), .bm_addr(bm_addr),
    .fwd_vld(fwd_vld), .fwd_hit(fwd_hit), .fwd_chunk(fwd_chunk),
    .in_vld(in_vld), .in_dest(in_dest)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // reference: bit slicing of the address
  function automatic logic [5:0] model_out(input logic [31:0] a, input logic [31:0] en,
                                           input logic [31:0] c);
    logic [4:0] n;
    logic       h;
    n = a[27:23];
    h = (c[8:7] == 2'b01) && (a[31:28] == 4'hF) && (n != 5'd0) && (n != 5'd31) && en[n];
    return {h, h ? n : 5'd0};
  endfunction

  function automatic logic [1:0] model_in(input logic [31:0] a);
    if (a <= 32'hF07F_FFFF) return 2'd1;
    if (a <= 32'hFF7F_FFFF) return 2'd2;
    if (a >= 32'hFFF0_0000 && a <= 32'hFFFF_EFFF) return 2'd3;
    return 2'd0;
  endfunction

  task automatic out_try(input logic [31:0] a, input logic [31:0] en, input logic [31:0] c,
                         input string req);
    logic [5:0] e;
    cpu_addr = a; win_en = en; ctrl = c; cpu_vld = 1'b1;
    @(negedge clk);
    e = model_out(a, en, c);
    chk({req, " valid"}, {31'b0, fwd_vld}, 32'd1);
    chk({req, " hit"}, {31'b0, fwd_hit}, {31'b0, e[5]});
    chk({req, " chunk"}, {27'b0, fwd_chunk}, {27'b0, e[4:0]});
    cpu_vld = 1'b0;
  endtask

  task automatic in_try(input logic [31:0] a, input string req);
    bm_addr = a; bm_vld = 1'b1;
    @(negedge clk);
    chk({req, " in_vld"}, {31'b0, in_vld}, 32'd1);
    chk({req, " dest"}, {30'b0, in_dest}, {30'b0, model_in(a)});
    bm_vld = 1'b0;
  endtask

  function automatic string in_req(input logic [31:0] a);
    case (model_in(a))
      2'd1: return "R7";
      2'd2: return "R8";
      2'd3: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats[4];
    logic [31:0] offs[3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'h5555_5555; pats[3] = 32'hAAAA_AAAA;
    offs[0] = 32'h0; offs[1] = 32'h7F_FFFF; offs[2] = 32'h3A_5C00;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 fwd_vld", {31'b0, fwd_vld}, 0);
    chk("R1 fwd_hit", {31'b0, fwd_hit}, 0);
    chk("R1 fwd_chunk", {27'b0, fwd_chunk}, 0);
    chk("R1 in_vld", {31'b0, in_vld}, 0);
    chk("R1 in_dest", {30'b0, in_dest}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {30'b0, fwd_vld, in_vld}, 0);

    // R3 R4 R5 sweep: switch codes x enable patterns x chunks x offsets
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 32; k++)
          for (int o = 0; o < 3; o++) begin
            logic [31:0] noise;
            noise = (32'h1357_9BDF * (p + 1) + 32'(k)) & 32'hFFFF_FE7F;
            out_try(32'hF000_0000 + (32'(k) << 23) + offs[o], pats[p],
                    noise | (32'(s) << 7),
                    (k == 0 || k == 31) ? "R5 end chunk" : (s == 1 ? "R4 window" : "R3 switch"));
          end

    // R4 walking single enable, own and neighbour chunk
    for (int i = 0; i < 32; i++) begin
      out_try(32'hF000_0000 + (32'(i) << 23) + 32'h100, 32'd1 << i, 32'h80, "R4 walk own");
      out_try(32'hF000_0000 + (32'((i + 1) % 32) << 23), 32'd1 << i, 32'h80, "R4 walk other");
    end

    // R6 low space
    out_try(32'h0, 32'hFFFF_FFFF, 32'h80, "R6 zero");
    out_try(32'hEFFF_FFFF, 32'hFFFF_FFFF, 32'h80, "R6 below base");
    out_try(32'h8000_0000, 32'hFFFF_FFFF, 32'h80, "R6 mid");

    // R2 idle strobe
    @(negedge clk);
    chk("R2 fwd idle", {31'b0, fwd_vld}, 0);
    chk("R2 in idle", {31'b0, in_vld}, 0);

    // R11 hold, then new settings apply on next strobe
    out_try(32'hF100_0000, 32'hFFFF_FFFF, 32'h80, "R11 setup");
    win_en = 32'h0; ctrl = 32'h0;
    repeat (2) @(negedge clk);
    chk("R11 hold hit", {31'b0, fwd_hit}, 1);
    chk("R11 hold chunk", {27'b0, fwd_chunk}, 2);
    out_try(32'hF100_0000, 32'h0, 32'h0, "R11 next strobe");

    // R7 R8 R9 R10 inbound sweep and edges
    for (int k = 0; k < 4096; k++) begin
      logic [31:0] a;
      a = 32'(k) << 20;
      in_try(a, in_req(a));
    end
    in_try(32'hF07F_FFFF, "R7 edge");
    in_try(32'hF080_0000, "R8 edge low");
    in_try(32'hFF7F_FFFF, "R8 edge high");
    in_try(32'hFF80_0000, "R10 after pci");
    in_try(32'hFFEF_FFFF, "R10 before cpu");
    in_try(32'hFFF0_0000, "R9 edge low");
    in_try(32'hFFFF_EFFF, "R9 edge high");
    in_try(32'hFFFF_F000, "R10 after cpu");
    in_try(32'hFFFF_FFFF, "R10 top");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule